// File: doc/BRIEF.md
# Buffer descriptor ring engine

This block services two rings of buffer descriptors, one for transmit and one for receive, kept in a small descriptor store inside the block. Each descriptor is three 16-bit words: a status/control word, a byte length and a buffer address. Ownership passes between software and the engine through one bit per descriptor. Software sets that bit to hand a descriptor over, and the engine clears it when it has finished with the descriptor. The last descriptor of each ring carries a wrap bit, so the ring size is set by software and not by the hardware depth.

Software reaches the store and four control registers through a simple register port. It sets the first descriptor of each ring through a base register. It then starts a ring by writing the start code to that ring's activation register. The engine runs through owned descriptors in order. On transmit it presents the length and address of each ready descriptor to a MAC-side handshake, then writes back the retry count and clears ownership. On receive it counts the bytes of each incoming frame into the current empty descriptor, then writes back the length, the last-buffer flag and the error flags. When the engine meets a descriptor it does not own, it parks that ring until software writes the start code again.

Top module: `bd_ring_engine`

## Requirements
- R1: After reset both rings are inactive, both ring indices and both base registers are 0, every descriptor word reads 0 and `tx_req` is low.
- R2: With `reg_addr[7]`=0 and `reg_addr[6:2]` below the descriptor count, `reg_addr[6:2]` selects a descriptor and `reg_addr[1:0]` selects a word: 0 status, 1 length, 2 buffer address. Word 3 reads 0. A write stores `reg_wdata[15:0]` and a read returns it zero-extended.
- R3: Registers sit at `reg_addr[7]`=1 and are selected by `reg_addr[1:0]`: 0 receive base, 1 transmit base, 2 receive activation, 3 transmit activation. Writing exactly 0x01000000 to an activation register sets that ring active, and any other value has no effect. An activation register reads 0x01000000 while its ring is active and 0 otherwise.
- R4: An active, idle transmit ring whose current descriptor has status bit 15 (ready) set raises `tx_req` on the next clock. `tx_len` and `tx_addr` then show that descriptor's length and address words, and `tx_req` holds until `tx_done` is sampled high.
- R5: On `tx_done` the engine clears bit 15 of the current transmit descriptor and writes `tx_retry` into bits 5:2. All other status bits are kept, and the engine moves to the next descriptor.
- R6: After a descriptor whose status bit 13 (wrap) is set, the ring index returns to that ring's base. Otherwise it advances by one, modulo the descriptor count.
- R7: An active ring that is idle and whose current descriptor is not owned (bit 15 clear) becomes inactive and takes no further action until its activation register is written again.
- R8: A receive frame (`rx_vld` bytes from `rx_sof` through `rx_eof`) that starts while the ring is active and the current descriptor has bit 15 (empty) set is stored there. Bit 15 and bits 5:0 are cleared, bit 11 (last) is set, the length word receives the byte count, and the ring advances.
- R9: Receive error flags: bit 0 when the count exceeds 1520 bytes, in which case the length is capped at 1520; bit 1 when the count exceeds 1518; bit 2 when the count is below 64.
- R10: A frame that starts while the receive ring is inactive, or while its current descriptor is not empty, is dropped and leaves every descriptor unchanged.
- R11: Writing a base register also moves that ring's current index to the written value, and the register reads back the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register/descriptor write strobe |
| reg_addr | input | 8 | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| rx_vld | input | 1 | One received byte present |
| rx_sof | input | 1 | This byte starts a frame |
| rx_eof | input | 1 | This byte ends a frame |
| tx_req | output | 1 | Transmit descriptor presented to the MAC |
| tx_len | output | 16 | Length of the presented frame |
| tx_addr | output | 16 | Buffer address of the presented frame |
| tx_done | input | 1 | MAC finished the presented frame |
| tx_retry | input | 4 | Retry count of the finished frame |

## Verification
On every cycle the assertions check the transmit handshake. A request must persist until it is completed and must drop right after completion, and a request may only start from an active ring. They also check that a ring can only park itself while idle, never in the middle of a frame. Whether the right words are written back, whether wrap returns to the base, whether frames are counted and flagged correctly and whether dropped frames leave the store alone can only be shown by the bench. Its scenarios run both rings through wrap, parking, re-arming, and short, long and truncated frames, and compare the store and the transmit outputs against a reference model every clock.

// File: rtl/bd_ring_engine.sv
module bd_ring_engine #(
  parameter int NDESC     = 16,
  parameter int BUF_MAX   = 1520,
  parameter int FRAME_MAX = 1518,
  parameter int FRAME_MIN = 64,
  localparam int IW = $clog2(NDESC)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        rx_vld,
  input  logic        rx_sof,
  input  logic        rx_eof,
  output logic        tx_req,
  output logic [15:0] tx_len,
  output logic [15:0] tx_addr,
  input  logic        tx_done,
  input  logic [3:0]  tx_retry
);

  localparam logic [15:0] BMAX   = 16'(BUF_MAX);
  localparam logic [15:0] FMAX   = 16'(FRAME_MAX);
  localparam logic [15:0] FMIN   = 16'(FRAME_MIN);
  localparam logic [5:0]  NCOUNT = 6'(NDESC);
  localparam logic [31:0] GO     = 32'h0100_0000;

  logic [15:0] st [NDESC];
  logic [15:0] ln [NDESC];
  logic [15:0] ba [NDESC];

  logic [IW-1:0] rx_base, tx_base, rx_idx, tx_idx;
  logic          rx_act, tx_act, cap, tx_busy;
  logic [15:0]   cnt;

  function automatic logic [IW-1:0] step(input logic [IW-1:0] i);
    return (i == IW'(NDESC - 1)) ? '0 : i + 1'b1;
  endfunction

  wire          ram_ok  = !reg_addr[7] && ({1'b0, reg_addr[6:2]} < NCOUNT);
  wire [IW-1:0] sw_i    = reg_addr[2 +: IW];
  wire          go      = reg_wdata == GO;

  wire [15:0]   rx_cur  = st[rx_idx];
  wire [15:0]   tx_cur  = st[tx_idx];
  wire [IW-1:0] rx_nxt  = rx_cur[13] ? rx_base : step(rx_idx);
  wire [IW-1:0] tx_nxt  = tx_cur[13] ? tx_base : step(tx_idx);

  wire          take    = rx_vld && (rx_sof ? (rx_act && rx_cur[15]) : cap);
  wire [15:0]   fin     = rx_sof ? 16'd1 : ((cnt == 16'hFFFF) ? cnt : cnt + 16'd1);
  wire          rx_wb   = take && rx_eof;
  wire [15:0]   rx_len  = (fin > BMAX) ? BMAX : fin;
  wire [15:0]   rx_err  = {13'd0, fin < FMIN, fin > FMAX, fin > BMAX};
  wire          rx_stop = rx_act && !cap && !rx_cur[15] && !take;
  wire          tx_wb   = tx_busy && tx_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NDESC; k++) begin
        st[k] <= '0;
        ln[k] <= '0;
        ba[k] <= '0;
      end
      rx_base <= '0;
      tx_base <= '0;
      rx_idx  <= '0;
      tx_idx  <= '0;
      rx_act  <= 1'b0;
      tx_act  <= 1'b0;
      cap     <= 1'b0;
      tx_busy <= 1'b0;
      cnt     <= '0;
    end else begin
      if (reg_we && ram_ok) begin
        case (reg_addr[1:0])
          2'd0:    st[sw_i] <= reg_wdata[15:0];
          2'd1:    ln[sw_i] <= reg_wdata[15:0];
          2'd2:    ba[sw_i] <= reg_wdata[15:0];
          default: ;
        endcase
      end

      if (rx_vld) begin
        if (take) begin
          cnt <= fin;
          cap <= !rx_eof;
        end else begin
          cap <= 1'b0;
        end
      end
      if (rx_wb) begin
        st[rx_idx] <= (rx_cur & ~16'h803F) | 16'h0800 | rx_err;
        ln[rx_idx] <= rx_len;
        rx_idx     <= rx_nxt;
      end
      if (rx_stop) rx_act <= 1'b0;

      if (!tx_busy && tx_act) begin
        if (tx_cur[15]) tx_busy <= 1'b1;
        else            tx_act  <= 1'b0;
      end
      if (tx_wb) begin
        st[tx_idx] <= (tx_cur & ~16'h803C) | {10'd0, tx_retry, 2'b00};
        tx_idx     <= tx_nxt;
        tx_busy    <= 1'b0;
      end

      if (reg_we && reg_addr[7]) begin
        case (reg_addr[1:0])
          2'd0: begin rx_base <= reg_wdata[IW-1:0]; rx_idx <= reg_wdata[IW-1:0]; end
          2'd1: begin tx_base <= reg_wdata[IW-1:0]; tx_idx <= reg_wdata[IW-1:0]; end
          2'd2: if (go) rx_act <= 1'b1;
          2'd3: if (go) tx_act <= 1'b1;
        endcase
      end
    end
  end

  assign tx_req  = tx_busy;
  assign tx_len  = tx_busy ? ln[tx_idx] : 16'd0;
  assign tx_addr = tx_busy ? ba[tx_idx] : 16'd0;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[7]) begin
      case (reg_addr[1:0])
        2'd0: reg_rdata = 32'(rx_base);
        2'd1: reg_rdata = 32'(tx_base);
        2'd2: reg_rdata = rx_act ? GO : 32'd0;
        2'd3: reg_rdata = tx_act ? GO : 32'd0;
      endcase
    end else if (ram_ok) begin
      case (reg_addr[1:0])
        2'd0:    reg_rdata = {16'd0, st[sw_i]};
        2'd1:    reg_rdata = {16'd0, ln[sw_i]};
        2'd2:    reg_rdata = {16'd0, ba[sw_i]};
        default: reg_rdata = '0;
      endcase
    end
  end

  a_r4_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && !tx_done |=> tx_req);

  a_r5_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && tx_done |=> !tx_req);

  a_r3_req_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_req) |-> $past(tx_act));

  a_r7_tx_parks_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_act) |-> $past(!tx_req));

  a_r7_rx_parks_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_act) |-> $past(!cap));

endmodule

// File: tb/bd_ring_engine_bench.sv
module bd_ring_engine_bench;
  localparam int PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        rx_vld = 0, rx_sof = 0, rx_eof = 0;
  logic        tx_req;
  logic [15:0] tx_len, tx_addr;
  logic        tx_done = 0;
  logic [3:0]  tx_retry = 0;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  bd_ring_engine u_bd_ring_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_vld(rx_vld),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .tx_req(tx_req), .tx_len(tx_len),
    .tx_addr(tx_addr), .tx_done(tx_done), .tx_retry(tx_retry));

  logic [15:0] m_st [16];
  logic [15:0] m_ln [16];
  logic [15:0] m_ba [16];
  int m_rxb, m_txb, m_rxi, m_txi, m_cnt;
  bit m_rxa, m_txa, m_cap, m_busy;

  function automatic int adv(int i, logic [15:0] s, int b);
    return s[13] ? b : (i + 1) % 16;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 16; k++) begin m_st[k] = 0; m_ln[k] = 0; m_ba[k] = 0; end
      m_rxb = 0; m_txb = 0; m_rxi = 0; m_txi = 0; m_cnt = 0;
      m_rxa = 0; m_txa = 0; m_cap = 0; m_busy = 0;
    end else begin
      logic [15:0] rc, tc, e;
      bit ocap, obusy, otxa, acc;
      int n, l;
      rc = m_st[m_rxi]; tc = m_st[m_txi];
      ocap = m_cap; obusy = m_busy; otxa = m_txa;
      acc = rx_vld && (rx_sof ? (m_rxa && rc[15]) : ocap);
      n = rx_sof ? 1 : ((m_cnt + 1 > 65535) ? 65535 : m_cnt + 1);
      if (reg_we && !reg_addr[7] && reg_addr[6:2] < 16) begin
        case (reg_addr[1:0])
          0: m_st[reg_addr[5:2]] = reg_wdata[15:0];
          1: m_ln[reg_addr[5:2]] = reg_wdata[15:0];
          2: m_ba[reg_addr[5:2]] = reg_wdata[15:0];
          default: ;
        endcase
      end
      if (rx_vld) begin
        if (acc) begin m_cnt = n; m_cap = !rx_eof; end
        else m_cap = 0;
      end
      if (acc && rx_eof) begin
        e = 0;
        if (n > 1520) e[0] = 1;
        if (n > 1518) e[1] = 1;
        if (n < 64)   e[2] = 1;
        l = (n > 1520) ? 1520 : n;
        m_st[m_rxi] = (rc & 16'h7FC0) | 16'h0800 | e;
        m_ln[m_rxi] = 16'(l);
        m_rxi = adv(m_rxi, rc, m_rxb);
      end
      if (m_rxa && !ocap && !rc[15] && !acc) m_rxa = 0;
      if (!obusy && otxa) begin
        if (tc[15]) m_busy = 1; else m_txa = 0;
      end
      if (obusy && tx_done) begin
        m_st[m_txi] = (tc & 16'h7FC3) | {10'd0, tx_retry, 2'b00};
        m_txi = adv(m_txi, tc, m_txb);
        m_busy = 0;
      end
      if (reg_we && reg_addr[7]) begin
        case (reg_addr[1:0])
          0: begin m_rxb = int'(reg_wdata[3:0]); m_rxi = m_rxb; end
          1: begin m_txb = int'(reg_wdata[3:0]); m_txi = m_txb; end
          2: if (reg_wdata == 32'h0100_0000) m_rxa = 1;
          3: if (reg_wdata == 32'h0100_0000) m_txa = 1;
        endcase
      end
    end
  end

  function automatic logic [31:0] m_rd(logic [7:0] a);
    if (a[7]) begin
      case (a[1:0])
        0: return 32'(m_rxb);
        1: return 32'(m_txb);
        2: return m_rxa ? 32'h0100_0000 : 0;
        default: return m_txa ? 32'h0100_0000 : 0;
      endcase
    end
    if (a[6:2] >= 16) return 0;
    case (a[1:0])
      0: return {16'd0, m_st[a[5:2]]};
      1: return {16'd0, m_ln[a[5:2]]};
      2: return {16'd0, m_ba[a[5:2]]};
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R4 tx_req", 32'(tx_req), 32'(m_busy));
      chk("R4 tx_len", 32'(tx_len), m_busy ? 32'(m_ln[m_txi]) : 0);
      chk("R4 tx_addr", 32'(tx_addr), m_busy ? 32'(m_ba[m_txi]) : 0);
      chk("R2 reg_rdata", reg_rdata, m_rd(reg_addr));
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); #1 reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1 reg_we = 0;
  endtask

  task automatic desc(int i, logic [15:0] s, logic [15:0] l, logic [15:0] b);
    wr(8'(i * 4 + 1), 32'(l));
    wr(8'(i * 4 + 2), 32'(b));
    wr(8'(i * 4), 32'(s));
  endtask

  task automatic expect_rd(string tag, logic [7:0] a, logic [31:0] exp);
    @(negedge clk); #1 reg_addr = a; #1 chk(tag, reg_rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mac_finish(logic [3:0] r);
    int w = 0;
    while (!tx_req && w < 50) begin @(negedge clk); w++; end
    idle(2);
    #1 tx_done = 1; tx_retry = r;
    @(negedge clk); #1 tx_done = 0; tx_retry = 0;
  endtask

  task automatic frame(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1 rx_vld = 1; rx_sof = (i == 0); rx_eof = (i == n - 1);
    end
    @(negedge clk); #1 rx_vld = 0; rx_sof = 0; rx_eof = 0;
    idle(2);
  endtask

  initial begin
    idle(4);
    #1 rst_n = 1;
    // R1: reset state
    expect_rd("R1 rx active", 8'h82, 0);
    expect_rd("R1 tx active", 8'h83, 0);
    expect_rd("R1 desc status", 8'h00, 0);
    chk("R1 tx_req", 32'(tx_req), 0);
    // R2: descriptor store
    desc(0, 16'h8800, 16'd100, 16'h1000);
    desc(1, 16'hA800, 16'd200, 16'h2000);
    desc(2, 16'h8800, 16'd64,  16'h3000);
    expect_rd("R2 status word", 8'h04, 32'h0000_A800);
    expect_rd("R2 length word", 8'h05, 32'd200);
    expect_rd("R2 word3 zero", 8'h07, 0);
    // R3: wrong code ignored
    wr(8'h83, 32'h0000_0001);
    idle(3);
    expect_rd("R3 ignored code", 8'h83, 0);
    chk("R3 no request", 32'(tx_req), 0);
    // R4/R5/R6/R7: transmit ring
    wr(8'h83, 32'h0100_0000);
    idle(1);
    chk("R4 request len", 32'(tx_len), 32'd100);
    mac_finish(4'd3);
    mac_finish(4'd0);
    idle(3);
    expect_rd("R5 retry writeback", 8'h00, 32'h0000_080C);
    expect_rd("R5 wrap kept", 8'h04, 32'h0000_2800);
    expect_rd("R7 tx parked", 8'h83, 0);
    wr(8'h00, 32'h8800);
    idle(4);
    chk("R7 parked no req", 32'(tx_req), 0);
    wr(8'h83, 32'h0100_0000);
    idle(1);
    chk("R6 wrapped to base", 32'(tx_len), 32'd100);
    mac_finish(4'd1);
    idle(3);
    // R11: base register
    wr(8'h81, 32'd2);
    expect_rd("R11 base readback", 8'h81, 32'd2);
    wr(8'h83, 32'h0100_0000);
    idle(1);
    chk("R11 index moved", 32'(tx_len), 32'd64);
    mac_finish(4'd15);
    idle(3);
    expect_rd("R5 max retry", 8'h08, 32'h0000_083C);
    // R8/R9/R10: receive ring at base 4
    desc(4, 16'h8000, 16'd0, 16'h4000);
    desc(5, 16'hA000, 16'd0, 16'h5000);
    wr(8'h80, 32'd4);
    wr(8'h82, 32'h0100_0000);
    expect_rd("R3 active readback", 8'h82, 32'h0100_0000);
    frame(100);
    expect_rd("R8 status", 8'h10, 32'h0000_0800);
    expect_rd("R8 length", 8'h11, 32'd100);
    frame(1519);
    expect_rd("R9 too long", 8'h14, 32'h0000_2802);
    expect_rd("R9 long length", 8'h15, 32'd1519);
    expect_rd("R7 rx parked", 8'h82, 0);
    frame(50);
    expect_rd("R10 dropped status", 8'h10, 32'h0000_0800);
    expect_rd("R10 dropped length", 8'h11, 32'd100);
    wr(8'h10, 32'h803F);
    wr(8'h82, 32'h0100_0000);
    frame(30);
    expect_rd("R9 short", 8'h10, 32'h0000_0804);
    expect_rd("R9 short length", 8'h11, 32'd30);
    wr(8'h14, 32'hA000);
    wr(8'h82, 32'h0100_0000);
    frame(1530);
    expect_rd("R9 truncated", 8'h14, 32'h0000_2803);
    expect_rd("R9 capped length", 8'h15, 32'd1520);
    frame(64);
    expect_rd("R10 inactive drop", 8'h10, 32'h0000_0804);
    idle(5);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule